// File: doc/BRIEF.md
# Video Lock Status Monitor

This block watches the timing of a digital composite video decoder and reports its lock condition in one read-only status byte. It runs on the pixel clock. It decides horizontal lock by a majority vote over each field. It also records whether colour burst energy was present and whether the subcarrier phase error was within tolerance, and it reports a per-line average of the sync-tip level from the converter.

Horizontal lock is judged by counting syncs per field. Each horizontal sync event is compared with the position where it was expected. The sync counts as in-window when it lies at most 15 pixels away, and as out-of-window otherwise. At the field strobe the larger count wins. The burst flags are sampled once per burst strobe and held until the next one. The subcarrier lock bit is masked whenever horizontal lock is lost.

Top module: `vlock_status_mon`

## Requirements
- R1: The status byte carries burst-detect in bit 7, gated burst-lock in bit 6, horizontal-unlock in bit 5 and the averaged sync tip in bits 4:0. It reflects a strobe's inputs at the second rising clock edge after the strobe cycle.
- R2: While and after synchronous reset, before any strobe, the status byte is 8'h20: horizontal-unlock is 1 and every other bit is 0.
- R3: A sync event counts as in-window when |position - expected| <= 15, and as out-of-window otherwise. At a field strobe, bit 5 becomes 1 if the out-of-window count is greater than the in-window count, and 0 otherwise, so a tie gives locked. A sync on the strobe cycle belongs to the field being closed.
- R4: Bit 5 changes only in response to a field strobe and holds its value between field strobes.
- R5: A field with no sync events at all sets bit 5 to 1.
- R6: Both field counts are 10 bits wide. They saturate at 1023 and are cleared at every field strobe.
- R7: At each burst strobe, burst-detect takes the high-frequency indication. It holds that value until the next burst strobe.
- R8: At each burst strobe, the internal burst-lock flag becomes 1 when |phase error| <= threshold, and 0 otherwise. The phase error is two's complement and the threshold is unsigned. The flag holds until the next burst strobe.
- R9: Bit 6 is forced to 0 while bit 5 is 1. It shows the held burst-lock flag again once bit 5 returns to 0.
- R10: The sync-tip field takes the sum of the first 16 valid samples of a line shifted right by 4, latched at the line strobe. Further samples in that line are ignored. A sample presented on the line-strobe cycle is discarded.
- R11: If fewer than 16 samples arrived in a line, the sync-tip field keeps its previous value at that line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_evt_i | input | 1 | One-cycle horizontal sync detection |
| hsync_pos_i | input | 12 | Pixel position of the detected sync |
| hsync_exp_i | input | 12 | Expected sync position |
| field_stb_i | input | 1 | Field boundary strobe |
| line_stb_i | input | 1 | Line boundary strobe |
| burst_stb_i | input | 1 | End-of-burst-interval strobe |
| hf_seen_i | input | 1 | High-frequency energy seen in the burst interval |
| phase_err_i | input | 12 | Signed subcarrier phase error |
| lock_thr_i | input | 12 | Unsigned phase lock threshold |
| tip_vld_i | input | 1 | Sync-tip sample valid |
| tip_sample_i | input | 5 | Sync-tip sample from the converter |
| status_o | output | 8 | Packed lock status byte |

## Verification
Counter saturation is the hardest state to reach from the ports. It needs more than a thousand sync events inside a single field. The stimulus uses 1000 in-window and 1100 out-of-window syncs. With saturation the out-of-window count wins. A wrapping counter would make the in-window count win, so this one field can tell the two apart. The masking of bit 6 also needs a set order: first a locked field, then a good burst, then an empty field, then a locked field again. This shows that the held flag comes back without a new burst.

// File: rtl/vlock_pkg.sv
package vlock_pkg;
  localparam int TIP_W = 5;

  typedef struct packed {
    logic             burst_det;
    logic             burst_lock;
    logic             h_unlock;
    logic [TIP_W-1:0] tip;
  } vstat_t;

  localparam vstat_t VSTAT_RST = '{burst_det: 1'b0, burst_lock: 1'b0,
                                   h_unlock: 1'b1, tip: '0};
endpackage

// File: rtl/vlock_hvote.sv
module vlock_hvote #(
  parameter int PIX_W = 12,
  parameter int WIN   = 15,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_evt,
  input  logic [PIX_W-1:0] hs_pos,
  input  logic [PIX_W-1:0] hs_exp,
  input  logic             field_stb,
  output logic             hunlock_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic signed [PIX_W:0] diff;
  logic        [PIX_W:0] mag;
  logic                  in_win;
  logic [CNT_W-1:0]      in_cnt, out_cnt, in_nx, out_nx;

  always_comb begin
    diff   = $signed({1'b0, hs_pos}) - $signed({1'b0, hs_exp});
    mag    = diff[PIX_W] ? $unsigned(-diff) : $unsigned(diff);
    in_win = (mag <= (PIX_W+1)'(WIN));
    in_nx  = in_cnt  + {{(CNT_W-1){1'b0}}, (hs_evt &  in_win & (in_cnt  != CMAX))};
    out_nx = out_cnt + {{(CNT_W-1){1'b0}}, (hs_evt & ~in_win & (out_cnt != CMAX))};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt    <= '0;
      out_cnt   <= '0;
      hunlock_o <= 1'b1;
    end else if (field_stb) begin
      in_cnt    <= '0;
      out_cnt   <= '0;
      hunlock_o <= ((in_nx == '0) && (out_nx == '0)) ? 1'b1 : (out_nx > in_nx);
    end else begin
      in_cnt    <= in_nx;
      out_cnt   <= out_nx;
    end
  end

  // R4
  hlock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(field_stb)) |-> $stable(hunlock_o));

  // R5
  empty_field_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(field_stb) && !$past(hs_evt) &&
     ($past(in_cnt) == '0) && ($past(out_cnt) == '0)) |-> hunlock_o);

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_cnt == CMAX) && !field_stb) |=> (out_cnt == CMAX));
endmodule

// File: rtl/vlock_burst.sv
module vlock_burst #(
  parameter int PH_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   burst_stb,
  input  logic                   hf_seen,
  input  logic signed [PH_W-1:0] ph_err,
  input  logic        [PH_W-1:0] thr,
  output logic                   det_o,
  output logic                   lock_o
);
  logic [PH_W-1:0] mag;

  always_comb begin
    mag = ph_err[PH_W-1] ? (~ph_err + 1'b1) : ph_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_o  <= 1'b0;
      lock_o <= 1'b0;
    end else if (burst_stb) begin
      det_o  <= hf_seen;
      lock_o <= (mag <= thr);
    end
  end

  // R7
  det_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(burst_stb)) |-> $stable(det_o));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(burst_stb)) |-> $stable(lock_o));
endmodule

// File: rtl/vlock_tip.sv
module vlock_tip #(
  parameter int TIP_W    = 5,
  parameter int NSMP_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_stb,
  input  logic             smp_vld,
  input  logic [TIP_W-1:0] smp,
  output logic [TIP_W-1:0] tip_o
);
  localparam int ACC_W = TIP_W + NSMP_LOG;
  localparam logic [NSMP_LOG:0] NSMP = (NSMP_LOG+1)'(1 << NSMP_LOG);

  logic [ACC_W-1:0]  acc;
  logic [NSMP_LOG:0] cnt;
  logic              full;

  always_comb full = (cnt == NSMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      cnt   <= '0;
      tip_o <= '0;
    end else if (line_stb) begin
      if (full) tip_o <= acc[ACC_W-1:NSMP_LOG];
      acc <= '0;
      cnt <= '0;
    end else if (smp_vld && !full) begin
      acc <= acc + {{NSMP_LOG{1'b0}}, smp};
      cnt <= cnt + 1'b1;
    end
  end

  // R11
  tip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(line_stb)) |-> $stable(tip_o));

  // R10
  smp_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !line_stb) |=> $stable(acc));
endmodule

// File: rtl/vlock_status_mon.sv
module vlock_status_mon
  import vlock_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int PH_W     = 12,
  parameter int WIN      = 15,
  parameter int CNT_W    = 10,
  parameter int NSMP_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_evt_i,
  input  logic [PIX_W-1:0] hsync_pos_i,
  input  logic [PIX_W-1:0] hsync_exp_i,
  input  logic             field_stb_i,
  input  logic             line_stb_i,
  input  logic             burst_stb_i,
  input  logic             hf_seen_i,
  input  logic [PH_W-1:0]  phase_err_i,
  input  logic [PH_W-1:0]  lock_thr_i,
  input  logic             tip_vld_i,
  input  logic [TIP_W-1:0] tip_sample_i,
  output logic [7:0]       status_o
);
  logic             hunl, bdet, block;
  logic [TIP_W-1:0] tip;
  vstat_t           stat_q;

  vlock_hvote #(.PIX_W(PIX_W), .WIN(WIN), .CNT_W(CNT_W)) u_hvote (
    .clk(clk), .rst(rst), .hs_evt(hsync_evt_i), .hs_pos(hsync_pos_i),
    .hs_exp(hsync_exp_i), .field_stb(field_stb_i), .hunlock_o(hunl));

  vlock_burst #(.PH_W(PH_W)) u_burst (
    .clk(clk), .rst(rst), .burst_stb(burst_stb_i), .hf_seen(hf_seen_i),
    .ph_err($signed(phase_err_i)), .thr(lock_thr_i), .det_o(bdet), .lock_o(block));

  vlock_tip #(.TIP_W(TIP_W), .NSMP_LOG(NSMP_LOG)) u_tip (
    .clk(clk), .rst(rst), .line_stb(line_stb_i), .smp_vld(tip_vld_i),
    .smp(tip_sample_i), .tip_o(tip));

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= VSTAT_RST;
    end else begin
      stat_q.burst_det  <= bdet;
      stat_q.burst_lock <= block & ~hunl;
      stat_q.h_unlock   <= hunl;
      stat_q.tip        <= tip;
    end
  end

  assign status_o = stat_q;

  // R9
  lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[6] |-> !status_o[5]);

  // R2
  reset_val_chk: assert property (@(posedge clk)
    $past(rst) |-> (status_o == 8'h20));
endmodule

// File: tb/vlock_status_mon_tb_top.sv
module vlock_status_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_evt_i = 1'b0;
  logic [11:0] hsync_pos_i = '0;
  logic [11:0] hsync_exp_i = 12'd1000;
  logic        field_stb_i = 1'b0, line_stb_i = 1'b0, burst_stb_i = 1'b0;
  logic        hf_seen_i = 1'b0;
  logic [11:0] phase_err_i = '0, lock_thr_i = '0;
  logic        tip_vld_i = 1'b0;
  logic [4:0]  tip_sample_i = '0;
  logic [7:0]  status_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vlock_status_mon dut_i (.*);

  // {hf, err, thr, exp_det, exp_lock}
  localparam logic [26:0] BVEC [0:7] = '{
    {1'b1, 12'h028, 12'h028, 1'b1, 1'b1},
    {1'b0, 12'h029, 12'h028, 1'b0, 1'b0},
    {1'b1, 12'hFD8, 12'h028, 1'b1, 1'b1},
    {1'b0, 12'hFD7, 12'h028, 1'b0, 1'b0},
    {1'b1, 12'h800, 12'hFFF, 1'b1, 1'b1},
    {1'b1, 12'h000, 12'h000, 1'b1, 1'b1},
    {1'b0, 12'h001, 12'h000, 1'b0, 1'b0},
    {1'b1, 12'hFFF, 12'h000, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sync_at(input logic [11:0] pos);
    @(negedge clk);
    hsync_evt_i = 1'b1; hsync_pos_i = pos;
    @(negedge clk);
    hsync_evt_i = 1'b0;
  endtask

  task automatic end_field();
    @(negedge clk); field_stb_i = 1'b1;
    @(negedge clk); field_stb_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic burst(input logic hf, input logic [11:0] err, input logic [11:0] thr);
    @(negedge clk);
    burst_stb_i = 1'b1; hf_seen_i = hf; phase_err_i = err; lock_thr_i = thr;
    @(negedge clk); burst_stb_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic tip_line(input int n, input logic [4:0] base, input logic step);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tip_vld_i = 1'b1; tip_sample_i = step ? base + 5'(k) : base;
    end
    @(negedge clk); tip_vld_i = 1'b0;
  endtask

  task automatic end_line(input logic smp_on_stb);
    @(negedge clk); line_stb_i = 1'b1;
    tip_vld_i = smp_on_stb; tip_sample_i = 5'd0;
    @(negedge clk); line_stb_i = 1'b0; tip_vld_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset value", status_o, 8'h20);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 after reset", status_o, 8'h20);

    // R3: 3 in-window (0, +15, -15), 1 out (+16) -> locked
    sync_at(12'd1000); sync_at(12'd1015); sync_at(12'd985); sync_at(12'd1016);
    end_field();
    chk("R3 majority in", {7'd0, status_o[5]}, 8'd0);

    // R4: out-of-window syncs without a field strobe leave bit 5 alone
    for (int k = 0; k < 5; k++) sync_at(12'd1100);
    repeat (2) @(negedge clk);
    chk("R4 hold", {7'd0, status_o[5]}, 8'd0);
    end_field();
    chk("R3 majority out", {7'd0, status_o[5]}, 8'd1);

    // R3 tie -> locked
    sync_at(12'd1000); sync_at(12'd1010); sync_at(12'd984); sync_at(12'd2000);
    end_field();
    chk("R3 tie locked", {7'd0, status_o[5]}, 8'd0);

    // R3 boundary -16 alone -> unlocked
    sync_at(12'd984);
    end_field();
    chk("R3 minus16 out", {7'd0, status_o[5]}, 8'd1);

    // R5 empty field after locked field
    sync_at(12'd1000); end_field();
    end_field();
    chk("R5 empty field", {7'd0, status_o[5]}, 8'd1);

    // lock again, then walk burst vectors (R7, R8, R1)
    sync_at(12'd1000); end_field();
    for (int i = 0; i < 8; i++) begin
      burst(BVEC[i][26], BVEC[i][25:14], BVEC[i][13:2]);
      chk($sformatf("R7/R8 vector %0d", i), {6'd0, status_o[7:6]}, {6'd0, BVEC[i][1:0]});
    end

    // R7 hold: hf changes without a strobe
    burst(1'b1, 12'd0, 12'd5);
    @(negedge clk); hf_seen_i = 1'b0; phase_err_i = 12'd500;
    repeat (3) @(negedge clk);
    chk("R7/R8 hold", {6'd0, status_o[7:6]}, 8'd3);

    // R9 masking then recovery
    end_field();
    chk("R9 masked", {5'd0, status_o[7:5]}, 8'b101);
    sync_at(12'd1000); end_field();
    chk("R9 restored", {5'd0, status_o[7:5]}, 8'b110);

    // R6 saturation: 1000 in, 1100 out -> unlocked only if saturating
    for (int k = 0; k < 1000; k++) sync_at(12'd1000);
    for (int k = 0; k < 1100; k++) sync_at(12'd0);
    end_field();
    chk("R6 saturate", {7'd0, status_o[5]}, 8'd1);
    sync_at(12'd1000); end_field();
    chk("R6 cleared", {7'd0, status_o[5]}, 8'd0);

    // R10 sync tip average: 0..15 -> 7
    tip_line(16, 5'd0, 1'b1); end_line(1'b0);
    chk("R10 avg ramp", {3'd0, status_o[4:0]}, 8'd7);
    // R10 extras ignored
    tip_line(16, 5'd31, 1'b0); tip_line(3, 5'd0, 1'b0); end_line(1'b0);
    chk("R10 extra ignored", {3'd0, status_o[4:0]}, 8'd31);
    // R11 short line holds
    tip_line(5, 5'd2, 1'b0); end_line(1'b0);
    chk("R11 short hold", {3'd0, status_o[4:0]}, 8'd31);
    // R10 sample on strobe discarded, next line starts fresh
    tip_line(16, 5'd20, 1'b0); end_line(1'b1);
    chk("R10 steady 20", {3'd0, status_o[4:0]}, 8'd20);
    // R1 full byte layout
    chk("R1 byte", status_o, {1'b1, 1'b1, 1'b0, 5'd20});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule